// File: doc/BRIEF.md
# Conditional Jump Evaluator and Target Adder

This block resolves a short relative jump. Each cycle it may accept one 16-bit instruction word, the address that word was fetched from, and the four arithmetic status flags: negative, zero, carry and overflow. It checks that the word belongs to the jump format. It then tests the three-bit condition field against the flags and produces the next program counter.

The next program counter is the branch target when the condition holds. Otherwise it is the fall-through address. The target is the instruction address plus 2 plus twice a sign-extended 10-bit word offset, and it wraps modulo 2^16.

All results are registered and appear one cycle after the request. Alongside them, a qualifier tells the surrounding pipeline to leave the status flags untouched, and a separate error output marks a word whose top three bits do not select the jump format.

Top module: `jmp_unit`

## Requirements
- R1: `res_valid` is high exactly one cycle after `in_valid` was high. Synchronous reset clears `res_valid`, `taken`, `status_hold` and `bad_format`.
- R2: If `instr[15:13]` is not binary 001, then `bad_format` is 1, `taken` is 0, `status_hold` is 0, and `next_pc` is `instr_addr + 2`.
- R3: The condition field is `instr[12:10]`. Code 000 jumps when zero is 0, and code 001 jumps when zero is 1.
- R4: Code 010 jumps when carry is 0, and code 011 jumps when carry is 1.
- R5: Code 100 jumps when negative is 1. Code 101 jumps when negative equals overflow. Code 110 jumps when negative differs from overflow.
- R6: Code 111 always jumps, whatever the flags.
- R7: When the jump is taken, `next_pc` is `instr_addr + 2 + 2*off`. Here `off` is `instr[9:0]` read as two's complement, so the offset runs from -512 to +511 words.
- R8: When a well-formed jump is not taken, `next_pc` is `instr_addr + 2`.
- R9: `status_hold` is 1 with every valid result of a well-formed jump, and 0 whenever `res_valid` is 0.
- R10: The sum is taken modulo 2^16. A target past 0xFFFF wraps to low addresses, and a target below 0 wraps to high addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| instr | input | 16 | Instruction word to evaluate |
| instr_addr | input | 16 | Address of the instruction (even) |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_v | input | 1 | Overflow flag |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| taken | output | 1 | Jump condition held |
| next_pc | output | 16 | Target or fall-through address |
| status_hold | output | 1 | Flags must stay unchanged |
| bad_format | output | 1 | Word is not a jump |

## Verification
The assertions check several rules on every cycle:
- the one-cycle result latency;
- the fall-through address on every untaken or rejected word;
- the forced jump for code 111 and for code 000 with zero clear;
- the suppression of `status_hold` on rejected words.

Only the bench scenarios can show the remaining behaviour. These cover all eight condition codes under every flag combination, exact target sums at both offset extremes, and wrap-around in each direction. They also include fixed decodes such as 0x2FE4 as a carry-set jump of -28 words, 0x23FD at 0x8026 going to 0x8022, and 0x3FF3 at 0x802A going to 0x8012.

// File: rtl/jmp_pkg.sv
package jmp_pkg;

    localparam int INSTR_W = 16;
    localparam int OFF_W   = 10;
    localparam int COND_W  = 3;
    localparam int COND_LSB = OFF_W;
    localparam int FMT_LSB  = OFF_W + COND_W;
    localparam int FMT_W    = INSTR_W - FMT_LSB;
    localparam logic [FMT_W-1:0] FMT_JUMP = 3'b001;

    typedef enum logic [COND_W-1:0] {
        CC_NOT_ZERO = 3'd0,
        CC_ZERO     = 3'd1,
        CC_NO_CARRY = 3'd2,
        CC_CARRY    = 3'd3,
        CC_MINUS    = 3'd4,
        CC_SGN_GE   = 3'd5,
        CC_SGN_LT   = 3'd6,
        CC_ALWAYS   = 3'd7
    } cond_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic             fmt_ok;
        cond_e            cond;
        logic [OFF_W-1:0] off;
    } jdec_t;

    function automatic logic cond_holds(cond_e cc, flags_t f);
        logic r;
        case (cc)
            CC_NOT_ZERO: r = ~f.z;
            CC_ZERO:     r = f.z;
            CC_NO_CARRY: r = ~f.c;
            CC_CARRY:    r = f.c;
            CC_MINUS:    r = f.n;
            CC_SGN_GE:   r = ~(f.n ^ f.v);
            CC_SGN_LT:   r = f.n ^ f.v;
            default:     r = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
    import jmp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output jdec_t              dec
);
    always_comb begin
        dec.fmt_ok = (instr[INSTR_W-1:FMT_LSB] == FMT_JUMP);
        dec.cond   = cond_e'(instr[FMT_LSB-1:COND_LSB]);
        dec.off    = instr[OFF_W-1:0];
    end
endmodule

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
    import jmp_pkg::*;
(
    input  jdec_t  dec,
    input  flags_t flags,
    output logic   take
);
    always_comb begin
        take = dec.fmt_ok & cond_holds(dec.cond, flags);
    end
endmodule

// File: rtl/jmp_target_add.sv
module jmp_target_add #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 10
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [OFF_W-1:0]  off,
    input  logic              take,
    output logic [ADDR_W-1:0] next_pc
);
    localparam int EXT_W = ADDR_W - OFF_W - 1;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] byte_off;
    logic [ADDR_W-1:0] tgt_pc;

    always_comb begin
        seq_pc   = pc + STEP;
        byte_off = {{EXT_W{off[OFF_W-1]}}, off, 1'b0};
        tgt_pc   = seq_pc + byte_off;
        next_pc  = take ? tgt_pc : seq_pc;
    end
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
    import jmp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  instr_addr,
    input  logic               flag_n,
    input  logic               flag_z,
    input  logic               flag_c,
    input  logic               flag_v,
    output logic               res_valid,
    output logic               taken,
    output logic [ADDR_W-1:0]  next_pc,
    output logic               status_hold,
    output logic               bad_format
);
    jdec_t             dec;
    flags_t            flags;
    logic              take;
    logic [ADDR_W-1:0] npc;

    assign flags = '{n: flag_n, z: flag_z, c: flag_c, v: flag_v};

    jmp_decode u_dec (.instr(instr), .dec(dec));

    jmp_cond_eval u_cond (.dec(dec), .flags(flags), .take(take));

    jmp_target_add #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_add (
        .pc(instr_addr), .off(dec.off), .take(take), .next_pc(npc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            taken       <= 1'b0;
            next_pc     <= '0;
            status_hold <= 1'b0;
            bad_format  <= 1'b0;
        end else begin
            res_valid   <= in_valid;
            taken       <= in_valid & take;
            next_pc     <= npc;
            status_hold <= in_valid & dec.fmt_ok;
            bad_format  <= in_valid & ~dec.fmt_ok;
        end
    end

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    // R2
    bad_fmt_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && bad_format) |-> (!taken && !status_hold &&
                                       next_pc == $past(instr_addr) + ADDR_W'(2)));

    // R3
    ne_take_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:10] == 6'b001000 && !flag_z) |=> taken);

    // R6
    always_take_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && instr[15:10] == 6'b001111) |=> taken);

    // R8
    fallthru_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !taken) |-> next_pc == $past(instr_addr) + ADDR_W'(2));

    // R9
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (!status_hold && !taken && !bad_format));
endmodule

// File: tb/jmp_unit_test.sv
`timescale 1ns/1ps
module jmp_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [15:0] instr_addr = '0;
    logic        flag_n = 1'b0, flag_z = 1'b0, flag_c = 1'b0, flag_v = 1'b0;
    logic        res_valid, taken, status_hold, bad_format;
    logic [15:0] next_pc;

    always #2.5 clk = ~clk;

    jmp_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .instr_addr(instr_addr), .flag_n(flag_n), .flag_z(flag_z),
        .flag_c(flag_c), .flag_v(flag_v), .res_valid(res_valid),
        .taken(taken), .next_pc(next_pc), .status_hold(status_hold),
        .bad_format(bad_format)
    );

    typedef struct {
        logic        tk;
        logic [15:0] pc;
        logic        hold;
        logic        err;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 0;

    function automatic logic model_take(logic [2:0] cc, logic n, logic z, logic c, logic v);
        case (cc)
            3'd0: return !z;
            3'd1: return z;
            3'd2: return !c;
            3'd3: return c;
            3'd4: return n;
            3'd5: return n == v;
            3'd6: return n != v;
            default: return 1'b1;
        endcase
    endfunction

    task automatic drive(input logic [15:0] w, input logic [15:0] a,
                         input logic [3:0] nzcv, input string tag);
        exp_t e;
        logic ok;
        logic tk;
        logic [15:0] disp;
        @(negedge clk);
        in_valid   = 1'b1;
        instr      = w;
        instr_addr = a;
        {flag_n, flag_z, flag_c, flag_v} = nzcv;
        ok   = (w[15:13] == 3'b001);
        tk   = ok && model_take(w[12:10], nzcv[3], nzcv[2], nzcv[1], nzcv[0]);
        disp = {{5{w[9]}}, w[9:0], 1'b0};
        e.tk   = tk;
        e.pc   = tk ? (a + 16'd2 + disp) : (a + 16'd2);
        e.hold = ok;
        e.err  = !ok;
        e.tag  = tag;
        q.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            if (res_valid) begin
                checks++;
                if (q.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected result: actual res_valid=1 expected res_valid=0");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    if (taken !== e.tk || next_pc !== e.pc ||
                        status_hold !== e.hold || bad_format !== e.err) begin
                        errors++;
                        $display("FAIL %s actual tk=%0b pc=%h hold=%0b err=%0b expected tk=%0b pc=%h hold=%0b err=%0b",
                                 e.tag, taken, next_pc, status_hold, bad_format,
                                 e.tk, e.pc, e.hold, e.err);
                    end
                end
            end else if (status_hold !== 1'b0 || taken !== 1'b0) begin
                checks++;
                errors++;
                $display("FAIL R9 idle outputs: actual hold=%0b tk=%0b expected 0 0", status_hold, taken);
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        checks++;
        if (res_valid !== 1'b0 || status_hold !== 1'b0 || bad_format !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: actual v=%0b h=%0b e=%0b expected 0 0 0",
                     res_valid, status_hold, bad_format);
        end

        // R3 R4 R5 R6: every condition under every flag combination
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 16; f++) begin
                string tg;
                tg = (cc < 2) ? "R3" : (cc < 4) ? "R4" : (cc < 7) ? "R5" : "R6";
                drive({3'b001, 3'(cc), 10'(cc * 37 + f * 11)},
                      16'h8000 + 16'(f * 4), 4'(f), tg);
            end
        end

        // R7: fixed decodes; 0x2FE4 carry-set, -28 words
        drive(16'h2FE4, 16'h9000, 4'b0010, "R7");
        drive(16'h23FD, 16'h8026, 4'b0000, "R7");
        drive(16'h3FF3, 16'h802A, 4'b0000, "R7");
        drive({6'b001111, 10'h1FF}, 16'h4000, 4'b0000, "R7");
        drive({6'b001111, 10'h200}, 16'h4000, 4'b0000, "R7");
        // R8: not taken
        drive(16'h2FE4, 16'h9000, 4'b0000, "R8");
        drive(16'h23FD, 16'h8026, 4'b0100, "R8");
        // R10: wrap both ways
        drive({6'b001111, 10'h001}, 16'hFFFE, 4'b0000, "R10");
        drive({6'b001111, 10'h200}, 16'h0010, 4'b0000, "R10");
        // R2 R9: not a jump
        drive(16'h4504, 16'h8000, 4'b1111, "R2");
        drive(16'h0000, 16'h1234, 4'b0000, "R2");
        drive(16'hFFFF, 16'hFFFE, 4'b1111, "R2");
        idle();
        // R1: spaced requests
        drive(16'h3C05, 16'h0100, 4'b0000, "R1");
        idle();
        idle();
        drive(16'h2405, 16'h0100, 4'b0000, "R9");
        idle();
        repeat (4) @(negedge clk);

        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results: actual %0d pending expected 0", q.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule